// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit timer/counter for a microcontroller-class subsystem. A small byte-wide register port gives access to a control byte, a mode byte, the running count and a 16-bit reload/capture value. The count advances in one of three ways:
- once per machine cycle of 12 input clocks (timer),
- on falling edges of an external count pin, sampled once per machine cycle (event counter),
- once every 2 input clocks in the fast mode that feeds a serial baud tick and a clock-out pin.

A second external pin, `trig_pin`, has different roles depending on the mode. In capture mode it latches the count. In up-only reload mode it forces a reload. In up/down mode its level sets the count direction. In fast mode it only raises a flag.

The operating mode is picked by priority:
1. Fast mode, when control bit 5 or mode bit 1 is set.
2. Otherwise capture mode, when control bit 0 is set.
3. Otherwise up/down reload mode, when mode bit 0 is set.
4. Otherwise up-only reload mode.

Two sticky flags (overflow, external) drive the interrupt request. Software must clear them by writing the control byte. In up/down mode the external flag toggles on every wrap and so serves as a 17th count bit. In that mode it does not request an interrupt.

Top module: `multimode_timer16`

## Requirements
- R1: Register map by `reg_addr`:
  - 0 = control: bit7 overflow flag, bit6 external flag, bit5 fast mode, bit3 external enable, bit2 run, bit1 event source, bit0 capture select; bit4 reads 0.
  - 1 = mode: bit0 up/down enable, bit1 clock-out enable.
  - 2 = count low byte, 3 = count high byte.
  - 4 = reload low byte, 5 = reload high byte.
  
  After reset every register reads 0, and `irq`, `clk_out` and `baud_tick` are low.
- R2: In timer operation with run set, the count rises by exactly one every 12 clocks.
- R3: In up-only reload mode, a step from FFFFh loads the count from the reload register and sets the overflow flag.
- R4: With run clear and external enable clear, the count does not change. A register write takes effect on the next clock edge whether or not run is set.
- R5: With the event source selected, `evt_pin` is sampled once per 12-clock machine cycle. The count rises by one for each sample pair that reads high and then low.
- R6: In capture mode with external enable set, a falling edge on `trig_pin` (sampled as in R5) copies the count into the reload register and sets the external flag. With external enable clear, the edge changes neither.
- R7: In capture mode, a step from FFFFh wraps the count to 0000h, sets the overflow flag and leaves the reload register unchanged.
- R8: In up-only reload mode with external enable set, a `trig_pin` falling edge loads the count from the reload register and sets the external flag.
- R9: In up/down mode with `trig_pin` low, the count falls by one per step. A step taken while the count equals the reload value loads FFFFh, sets the overflow flag and toggles the external flag. In this mode the external flag requests no interrupt.
- R10: In up/down mode with `trig_pin` high, the count rises by one per step. A step from FFFFh loads the reload value, sets the overflow flag and toggles the external flag.
- R11: In fast mode:
  - The count steps every 2 clocks.
  - A step from FFFFh reloads the count and gives a one-cycle `baud_tick` pulse, so the pulses repeat every 2*(65536-reload) clocks.
  - The overflow flag is never set.
  - A `trig_pin` falling edge with external enable set sets the external flag but causes no reload.
- R12: With clock-out enabled, `clk_out` toggles on every fast-mode rollover. It stays high for 2*(65536-reload) clocks and low for the same time.
- R13: `irq` is high while the overflow flag is set, or while the external flag is set outside up/down mode. Flags stay set until software writes the control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| evt_pin | input | 1 | External count input |
| trig_pin | input | 1 | External capture/reload trigger or count direction |
| irq | output | 1 | Interrupt request |
| clk_out | output | 1 | Square-wave clock output |
| baud_tick | output | 1 | One-cycle pulse per fast-mode rollover |

## Verification
The hardest state to reach from the ports is a wrap in up/down mode while counting down. It needs the direction pin held low across several machine cycles and the count placed exactly two steps above the reload value. The bench gets there with the event source selected: it writes the count directly, then produces each step as a slow high-low pulse on the count pin, so the step arrives at a known point whatever the prescaler phase. The timer-rate checks align to the prescaler by waiting for the overflow interrupt to rise, and count clocks from that edge. Reload values, start counts and step counts come from a seeded random stream.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int TMR_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_L = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_H = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_L = 3'd4;
  localparam logic [ADDR_W-1:0] A_RLD_H = 3'd5;

  // control byte bit positions
  localparam int B_CAP  = 0;
  localparam int B_EVT  = 1;
  localparam int B_RUN  = 2;
  localparam int B_XEN  = 3;
  localparam int B_FAST = 5;
  localparam int B_XF   = 6;
  localparam int B_OF   = 7;
  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'hEF;

  // mode byte bit positions
  localparam int M_UPDN = 0;
  localparam int M_CKO  = 1;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    OP_RELOAD_UP = 2'd0,
    OP_UPDOWN    = 2'd1,
    OP_CAPTURE   = 2'd2,
    OP_FAST      = 2'd3
  } op_e;
endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] div_q, div_d;

  assign tick = (div_q == LAST);

  always_comb begin
    div_d = tick ? '0 : div_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr16_pin_sampler.sv
module tmr16_pin_sampler #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_en,
  input  logic [N-1:0] pins,
  output logic [N-1:0] level
);
  logic [N-1:0] lvl_q;

  assign level = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (smp_en) lvl_q <= pins;
  end
endmodule

// File: rtl/tmr16_step_logic.sv
module tmr16_step_logic
  import tmr16_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  op_e          op,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] rld_q,
  input  logic         step,
  input  logic         xfall,
  input  logic         dir_up,
  output logic [W-1:0] cnt_d,
  output logic         cnt_en,
  output logic [W-1:0] rld_d,
  output logic         rld_en,
  output logic         of_set,
  output logic         xf_set,
  output logic         xf_tgl,
  output logic         roll
);
  localparam logic [W-1:0] ONE = W'(1);

  logic at_top;
  assign at_top = &cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    rld_d  = rld_q;
    rld_en = 1'b0;
    of_set = 1'b0;
    xf_set = 1'b0;
    xf_tgl = 1'b0;
    roll   = 1'b0;
    unique case (op)
      OP_FAST: begin
        if (step) begin
          cnt_en = 1'b1;
          if (at_top) begin
            cnt_d = rld_q;
            roll  = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        xf_set = xfall;
      end
      OP_CAPTURE: begin
        if (step) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + ONE;
          of_set = at_top;
        end
        if (xfall) begin
          rld_en = 1'b1;
          rld_d  = cnt_q;
          xf_set = 1'b1;
        end
      end
      OP_UPDOWN: begin
        if (step) begin
          cnt_en = 1'b1;
          if (dir_up) begin
            if (at_top) begin
              cnt_d  = rld_q;
              of_set = 1'b1;
              xf_tgl = 1'b1;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == rld_q) begin
              cnt_d  = '1;
              of_set = 1'b1;
              xf_tgl = 1'b1;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
      end
      default: begin
        if (xfall) begin
          cnt_en = 1'b1;
          cnt_d  = rld_q;
          xf_set = 1'b1;
        end else if (step) begin
          cnt_en = 1'b1;
          if (at_top) begin
            cnt_d  = rld_q;
            of_set = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/multimode_timer16.sv
module multimode_timer16
  import tmr16_pkg::*;
#(
  parameter int CNT_W    = TMR_W,
  parameter int MC_DIV   = 12,
  parameter int FAST_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              evt_pin,
  input  logic              trig_pin,
  output logic              irq,
  output logic              clk_out,
  output logic              baud_tick
);
  localparam int HI_W = CNT_W - BYTE_W;

  // reset: asynchronous assertion, synchronous release
  logic rs_q1, rs_q2, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_int_n = rs_q2;

  logic mc_tick, fast_tick;
  tmr16_prescale #(.DIV(MC_DIV))   u_mc_div   (.clk(clk), .rst_n(rst_int_n), .tick(mc_tick));
  tmr16_prescale #(.DIV(FAST_DIV)) u_fast_div (.clk(clk), .rst_n(rst_int_n), .tick(fast_tick));

  logic [1:0] pin_lvl;
  tmr16_pin_sampler #(.N(2)) u_pins (
    .clk(clk), .rst_n(rst_int_n), .smp_en(mc_tick),
    .pins({trig_pin, evt_pin}), .level(pin_lvl)
  );

  logic evt_fall, trig_fall;
  assign evt_fall  = mc_tick & pin_lvl[0] & ~evt_pin;
  assign trig_fall = mc_tick & pin_lvl[1] & ~trig_pin;

  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d, rld_q, rld_d;
  logic              cko_q, cko_d, tick_q;

  logic run_en, fast_mode, cko_en, xen, of_q;
  assign run_en    = ctrl_q[B_RUN];
  assign cko_en    = mode_q[M_CKO];
  assign fast_mode = ctrl_q[B_FAST] | cko_en;
  assign xen       = ctrl_q[B_XEN];
  assign of_q      = ctrl_q[B_OF];

  op_e op;
  always_comb begin
    if (fast_mode)            op = OP_FAST;
    else if (ctrl_q[B_CAP])   op = OP_CAPTURE;
    else if (mode_q[M_UPDN])  op = OP_UPDOWN;
    else                      op = OP_RELOAD_UP;
  end

  logic step;
  always_comb begin
    if (!run_en)             step = 1'b0;
    else if (fast_mode)      step = fast_tick;
    else if (ctrl_q[B_EVT])  step = evt_fall;
    else                     step = mc_tick;
  end

  logic [CNT_W-1:0] eng_cnt, eng_rld;
  logic eng_cnt_en, eng_rld_en, of_set, xf_set, xf_tgl, roll;
  tmr16_step_logic #(.W(CNT_W)) u_step (
    .op(op), .cnt_q(cnt_q), .rld_q(rld_q), .step(step),
    .xfall(xen & trig_fall), .dir_up(pin_lvl[1]),
    .cnt_d(eng_cnt), .cnt_en(eng_cnt_en), .rld_d(eng_rld), .rld_en(eng_rld_en),
    .of_set(of_set), .xf_set(xf_set), .xf_tgl(xf_tgl), .roll(roll)
  );

  logic wr_ctrl, wr_mode, wr_cl, wr_ch, wr_rl, wr_rh;
  assign wr_ctrl = reg_we & (reg_addr == A_CTRL);
  assign wr_mode = reg_we & (reg_addr == A_MODE);
  assign wr_cl   = reg_we & (reg_addr == A_CNT_L);
  assign wr_ch   = reg_we & (reg_addr == A_CNT_H);
  assign wr_rl   = reg_we & (reg_addr == A_RLD_L);
  assign wr_rh   = reg_we & (reg_addr == A_RLD_H);

  logic ctrl_ce, cnt_ce, rld_ce;
  assign ctrl_ce = wr_ctrl | of_set | xf_set | xf_tgl;
  assign cnt_ce  = eng_cnt_en | wr_cl | wr_ch;
  assign rld_ce  = eng_rld_en | wr_rl | wr_rh;

  always_comb begin
    ctrl_d       = ctrl_q;
    ctrl_d[B_OF] = ctrl_q[B_OF] | of_set;
    ctrl_d[B_XF] = xf_tgl ? ~ctrl_q[B_XF] : (ctrl_q[B_XF] | xf_set);
    if (wr_ctrl) ctrl_d = reg_wdata & CTRL_MASK;

    cnt_d = eng_cnt_en ? eng_cnt : cnt_q;
    if (wr_cl) cnt_d[BYTE_W-1:0]     = reg_wdata;
    if (wr_ch) cnt_d[CNT_W-1:BYTE_W] = reg_wdata[HI_W-1:0];

    rld_d = eng_rld_en ? eng_rld : rld_q;
    if (wr_rl) rld_d[BYTE_W-1:0]     = reg_wdata;
    if (wr_rh) rld_d[CNT_W-1:BYTE_W] = reg_wdata[HI_W-1:0];

    cko_d = cko_en & (roll ? ~cko_q : cko_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      cnt_q  <= '0;
      rld_q  <= '0;
      cko_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (wr_mode) mode_q <= reg_wdata[MODE_W-1:0];
      if (cnt_ce)  cnt_q  <= cnt_d;
      if (rld_ce)  rld_q  <= rld_d;
      cko_q  <= cko_d;
      tick_q <= roll;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_MODE:  reg_rdata = {{(BYTE_W-MODE_W){1'b0}}, mode_q};
      A_CNT_L: reg_rdata = cnt_q[BYTE_W-1:0];
      A_CNT_H: reg_rdata = cnt_q[CNT_W-1:BYTE_W];
      A_RLD_L: reg_rdata = rld_q[BYTE_W-1:0];
      A_RLD_H: reg_rdata = rld_q[CNT_W-1:BYTE_W];
      default: reg_rdata = '0;
    endcase
  end

  assign irq       = ctrl_q[B_OF] | (ctrl_q[B_XF] & (op != OP_UPDOWN));
  assign clk_out   = cko_q;
  assign baud_tick = tick_q;
endmodule

// File: rtl/tmr16_sva.sv
module tmr16_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic         run_en,
  input logic         xen,
  input logic         fast_mode,
  input logic         cko_en,
  input logic         of_q,
  input logic [W-1:0] cnt_q,
  input logic         baud_tick,
  input logic         clk_out
);
  // R4: stopped with external enable clear, the count holds
  a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !xen && !reg_we) |=> $stable(cnt_q));

  // R11: the baud pulse lasts one cycle
  a_r11_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  // R11: fast mode never raises the overflow flag
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_mode && !reg_we) |=> !$rose(of_q));

  // R13: the overflow flag is only cleared by software
  a_r13_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (of_q && !reg_we) |=> of_q);

  // R12: a clock-out edge coincides with a rollover pulse
  a_r12_edge_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cko_en) && !$past(reg_we) && (clk_out != $past(clk_out))) |-> baud_tick);
endmodule

bind multimode_timer16 tmr16_sva #(.W(CNT_W)) u_tmr16_sva (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .run_en(run_en), .xen(xen),
  .fast_mode(fast_mode), .cko_en(cko_en), .of_q(of_q), .cnt_q(cnt_q),
  .baud_tick(baud_tick), .clk_out(clk_out)
);

// File: tb/test_multimode_timer16.sv
module test_multimode_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       evt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic       irq, clk_out, baud_tick;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  multimode_timer16 i_multimode_timer16 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pin(evt_pin),
    .trig_pin(trig_pin), .irq(irq), .clk_out(clk_out), .baud_tick(baud_tick)
  );

  // register addresses and control encodings from R1
  localparam logic [2:0] AC = 3'd0, AM = 3'd1, ACL = 3'd2, ARL = 3'd4;
  localparam logic [7:0] C_CAP = 8'h01, C_EVT = 8'h02, C_RUN = 8'h04,
                         C_XEN = 8'h08, C_FAST = 8'h20, C_XF = 8'h40, C_OF = 8'h80;

  function automatic logic [15:0] f_up(input logic [15:0] s, input logic [15:0] r, input int n);
    logic [15:0] v = s;
    for (int i = 0; i < n; i++) v = (v == 16'hFFFF) ? r : v + 16'd1;
    return v;
  endfunction

  function automatic logic [15:0] f_down(input logic [15:0] s, input logic [15:0] r, input int n);
    logic [15:0] v = s;
    for (int i = 0; i < n; i++) v = (v == r) ? 16'hFFFF : v - 16'd1;
    return v;
  endfunction

  function automatic int f_fast_period(input logic [15:0] r);
    return 2 * (65536 - int'(r));
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    wr(a, d[7:0]);
    wr(a + 3'd1, d[15:8]);
  endtask

  task automatic rd_now(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd16_now(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd_now(a, lo); rd_now(a + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_now(a, d);
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd16_now(a, d);
  endtask

  task automatic pulse_evt();
    evt_pin = 1'b0; repeat (36) @(negedge clk);
    evt_pin = 1'b1; repeat (36) @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig_pin = 1'b0; repeat (36) @(negedge clk);
    trig_pin = 1'b1; repeat (36) @(negedge clk);
  endtask

  task automatic wait_irq();
    int g = 0;
    while (!irq && g < 2000) begin @(negedge clk); g++; end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!baud_tick && n < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, r, x;
    int n, m, p;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd_now(3'(a), b);
      chk(b == 8'h00, "R1 reset register", b, 0);
    end
    chk(irq == 1'b0 && clk_out == 1'b0 && baud_tick == 1'b0, "R1 reset outputs",
        {irq, clk_out, baud_tick}, 0);

    // R4: writes land while stopped; count frozen
    x = 16'($urandom);
    wr16(ACL, x);
    rd16(ACL, v);
    chk(v == x, "R4 write while stopped", v, x);
    repeat (60) @(negedge clk);
    rd16(ACL, v);
    chk(v == x, "R4 frozen count", v, x);

    // R2, R3, R13: timer rate and reload on overflow, aligned to irq
    for (int it = 0; it < 3; it++) begin
      r = 16'($urandom % 16'hF000);
      n = 1 + ($urandom % 150);
      wr(AC, 8'h00);
      wr16(ARL, r);
      wr16(ACL, 16'hFFFF);
      wr(AC, C_RUN);
      wait_irq();
      rd16_now(ACL, v);
      chk(v == r, "R3 reload on overflow", v, r);
      rd_now(AC, b);
      chk(b == (C_OF | C_RUN), "R3 overflow flag", b, C_OF | C_RUN);
      repeat (12 * n) @(negedge clk);
      rd16_now(ACL, v);
      chk(v == f_up(r, r, n), "R2 one step per 12 clocks", v, f_up(r, r, n));
      chk(irq == 1'b1, "R13 flag held", irq, 1);
      wr(AC, 8'h00);
      chk(irq == 1'b0, "R13 software clear", irq, 0);
    end

    // R5: event counting
    for (int it = 0; it < 2; it++) begin
      x = 16'($urandom % 16'hFF00);
      n = 1 + ($urandom % 6);
      wr(AC, 8'h00);
      wr16(ACL, x);
      wr(AC, C_EVT | C_RUN);
      for (int k = 0; k < n; k++) pulse_evt();
      rd16(ACL, v);
      chk(v == f_up(x, 16'h0, n), "R5 event count", v, f_up(x, 16'h0, n));
    end

    // R6: capture on trigger edge, and ignored when external enable is clear
    x = 16'($urandom);
    wr(AC, 8'h00);
    wr16(ARL, 16'h0000);
    wr16(ACL, x);
    wr(AC, C_CAP | C_EVT | C_RUN);
    pulse_trig();
    rd16(ARL, v);
    chk(v == 16'h0000, "R6 no capture without enable", v, 0);
    rd(AC, b);
    chk(b[6] == 1'b0, "R6 no flag without enable", b, C_CAP | C_EVT | C_RUN);
    wr(AC, C_CAP | C_EVT | C_RUN | C_XEN);
    pulse_trig();
    rd16(ARL, v);
    chk(v == x, "R6 capture value", v, x);
    rd(AC, b);
    chk(b == (C_XF | C_CAP | C_EVT | C_RUN | C_XEN), "R6 external flag", b,
        C_XF | C_CAP | C_EVT | C_RUN | C_XEN);
    chk(irq == 1'b1, "R13 irq from external flag", irq, 1);

    // R7: capture-mode overflow wraps without reload
    wr(AC, 8'h00);
    r = 16'($urandom | 16'h0001);
    wr16(ARL, r);
    wr16(ACL, 16'hFFFF);
    wr(AC, C_CAP | C_RUN);
    wait_irq();
    rd16_now(ACL, v);
    chk(v == 16'h0000, "R7 wrap to zero", v, 0);
    rd16_now(ARL, v);
    chk(v == r, "R7 reload untouched", v, r);

    // R8: trigger forces reload in up-only mode
    x = 16'($urandom); r = 16'($urandom);
    wr(AC, 8'h00);
    wr16(ACL, x);
    wr16(ARL, r);
    wr(AC, C_EVT | C_RUN | C_XEN);
    pulse_trig();
    rd16(ACL, v);
    chk(v == r, "R8 trigger reload", v, r);
    rd(AC, b);
    chk(b[6] == 1'b1, "R8 external flag", b, C_XF);

    // R9: down count in up/down mode
    wr(AC, 8'h00);
    wr(AM, 8'h01);
    trig_pin = 1'b0;
    repeat (36) @(negedge clk);
    r = 16'($urandom % 16'hFF00);
    wr16(ARL, r);
    wr16(ACL, r + 16'd2);
    wr(AC, C_EVT | C_RUN);
    for (int k = 0; k < 3; k++) pulse_evt();
    rd16(ACL, v);
    chk(v == f_down(r + 16'd2, r, 3), "R9 underflow loads all ones", v, f_down(r + 16'd2, r, 3));
    rd(AC, b);
    chk(b == (C_OF | C_XF | C_EVT | C_RUN), "R9 flags after underflow", b, C_OF | C_XF | C_EVT | C_RUN);
    wr(AC, C_XF | C_EVT | C_RUN);
    chk(irq == 1'b0, "R9 external flag silent", irq, 0);

    // R10: up count in up/down mode
    trig_pin = 1'b1;
    repeat (36) @(negedge clk);
    wr16(ACL, 16'hFFFE);
    for (int k = 0; k < 2; k++) pulse_evt();
    rd16(ACL, v);
    chk(v == r, "R10 overflow reloads", v, r);
    rd(AC, b);
    chk(b == (C_OF | C_EVT | C_RUN), "R10 external flag toggled back", b, C_OF | C_EVT | C_RUN);
    wr(AC, 8'h00);
    wr(AM, 8'h00);

    // R11: fast-mode baud ticks
    for (int it = 0; it < 2; it++) begin
      m = 2 + ($urandom % 12);
      r = 16'hFFFF - 16'(m);
      wr(AC, 8'h00);
      wr16(ARL, r);
      wr16(ACL, r);
      wr(AC, C_FAST | C_RUN);
      wait_tick(p);
      @(negedge clk);
      chk(baud_tick == 1'b0, "R11 pulse width", baud_tick, 0);
      wait_tick(p);
      chk(p == f_fast_period(r) - 1, "R11 tick period", p + 1, f_fast_period(r));
      wait_tick(p);
      chk(p == f_fast_period(r), "R11 tick period", p, f_fast_period(r));
      rd(AC, b);
      chk(b[7] == 1'b0, "R11 no overflow flag", b, C_FAST | C_RUN);
    end
    wr(AC, C_FAST | C_RUN | C_XEN);
    pulse_trig();
    rd(AC, b);
    chk(b[6] == 1'b1, "R11 external flag in fast mode", b, C_FAST | C_RUN | C_XEN | C_XF);
    wait_tick(p);
    wait_tick(p);
    chk(p == f_fast_period(r), "R11 no reload on trigger", p, f_fast_period(r));

    // R12: clock-out square wave
    m = 2 + ($urandom % 12);
    r = 16'hFFFF - 16'(m);
    wr(AC, 8'h00);
    wr16(ARL, r);
    wr16(ACL, r);
    wr(AM, 8'h02);
    wr(AC, C_RUN);
    n = 0;
    while (clk_out && n < 500) begin @(negedge clk); n++; end
    n = 0;
    while (!clk_out && n < 500) begin @(negedge clk); n++; end
    n = 0;
    while (clk_out && n < 500) begin @(negedge clk); n++; end
    chk(n == f_fast_period(r), "R12 high time", n, f_fast_period(r));
    n = 0;
    while (!clk_out && n < 500) begin @(negedge clk); n++; end
    chk(n == f_fast_period(r), "R12 low time", n, f_fast_period(r));

    summary();
  end
endmodule